// File: doc/BRIEF.md
# Floating-Point Mantissa Rounding Unit

This block rounds an unrounded floating-point intermediate result. The input is a sign, a biased exponent, a 64-bit mantissa and three extra bits below the mantissa: guard, round and sticky. The block applies one of four rounding modes at a boundary chosen by a precision input. It returns the rounded mantissa and exponent, an inexact flag, and a trap request.

The precision input selects a kept width of 64, 53 or 24 mantissa bits. At a reduced width, the mantissa bits below the boundary fold into the guard, round and sticky positions. Those bits leave the block as zeros. When the increment carries out of the kept width, the mantissa shifts right by one and the exponent rises by one.

Results are registered, so each one appears one cycle after its input. Exponent range checks and denormal handling are left to neighbouring logic.

Top module: `rnd_unit`

## Requirements
- R1: When guard, round and sticky are all zero after folding at the selected precision, no increment is applied in any mode. The exponent and the kept mantissa bits pass through unchanged, and `out_inexact` is 0.
- R2: When any of guard, round or sticky is 1 after folding, `out_inexact` is 1.
- R3: `rnd_mode` 2'b10 rounds toward minus infinity: it adds one at the LSB only when the result is inexact and `in_sign` is 1. `rnd_mode` 2'b11 rounds toward plus infinity: it adds one at the LSB only when the result is inexact and `in_sign` is 0.
- R4: `rnd_mode` 2'b00 rounds to nearest. In the tie case (guard 1, round 0, sticky 0) it adds one only when the LSB is 1. Otherwise it adds one whenever guard is 1.
- R5: `rnd_mode` 2'b01 rounds toward zero: it never adds and only drops the bits below the LSB.
- R6: If the increment carries out of the kept width, the output mantissa is 1 in bit 63 and 0 below the boundary, and `out_exp` equals `in_exp` + 1. In every other case `out_exp` equals `in_exp`.
- R7: `rnd_prec` selects the kept width: 2'b00 gives 64 bits, 2'b01 gives 24 bits (LSB at mantissa bit 40), 2'b10 gives 53 bits (LSB at bit 11), and 2'b11 behaves as 2'b00. Output mantissa bits below the LSB are 0.
- R8: `out_valid` is 1 in the cycle after a cycle with `in_valid` 1 and is 0 otherwise. Output data change only on accepted inputs, and `out_sign` equals the accepted `in_sign`.
- R9: `out_trap` is 1 exactly when `out_valid` is 1, the result is inexact and `trap_en` was 1 for that input. The rounded result is delivered in either case.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operand valid |
| in_sign | input | 1 | Sign of the intermediate result |
| in_exp | input | EW | Biased exponent |
| in_mant | input | MW | Unrounded mantissa |
| in_guard | input | 1 | First bit below the mantissa |
| in_round | input | 1 | Second bit below the mantissa |
| in_sticky | input | 1 | OR of all lower bits |
| rnd_mode | input | 2 | Rounding mode |
| rnd_prec | input | 2 | Rounding precision |
| trap_en | input | 1 | Inexact trap enable |
| out_valid | output | 1 | Result valid |
| out_sign | output | 1 | Result sign |
| out_exp | output | EW | Rounded exponent |
| out_mant | output | MW | Rounded mantissa |
| out_inexact | output | 1 | Result was inexact |
| out_trap | output | 1 | Inexact trap request |

## Verification
Every mode is tried on both signs and on exact inputs, which separates the directed modes from each other and from toward-zero. Nearest mode is tried on a tie with the LSB even, a tie with the LSB odd, above half and below half, which separates the tie rule from plain rounding on the guard bit. Each precision is tried with bits that fold in from below the boundary, and with an input whose only nonzero bit is the input sticky bit, which shows where the LSB sits. All-ones mantissas exercise the carry and renormalization. Trap-enabled exact and inexact inputs separate the trap from the inexact flag.

// File: rtl/rnd_unit.sv
module rnd_unit #(
  parameter int MW    = 64,
  parameter int EW    = 16,
  parameter int SGL_W = 24,
  parameter int DBL_W = 53
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sign,
  input  logic [EW-1:0] in_exp,
  input  logic [MW-1:0] in_mant,
  input  logic          in_guard,
  input  logic          in_round,
  input  logic          in_sticky,
  input  logic [1:0]    rnd_mode,
  input  logic [1:0]    rnd_prec,
  input  logic          trap_en,
  output logic          out_valid,
  output logic          out_sign,
  output logic [EW-1:0] out_exp,
  output logic [MW-1:0] out_mant,
  output logic          out_inexact,
  output logic          out_trap
);
  localparam int IW = $clog2(MW + 3);
  localparam logic [IW-1:0] DROP_SGL = IW'(MW - SGL_W);
  localparam logic [IW-1:0] DROP_DBL = IW'(MW - DBL_W);
  localparam logic [MW+2:0] ONE = {{(MW+2){1'b0}}, 1'b1};

  logic [IW-1:0] drop;
  logic [MW+2:0] full, low_mask;
  logic          g, r, s, lsb, inexact, inc, carry;
  logic [MW-1:0] kept, rounded;
  logic [MW:0]   sum;

  always_comb begin
    case (rnd_prec)
      2'b01:   drop = DROP_SGL;
      2'b10:   drop = DROP_DBL;
      default: drop = '0;
    endcase
  end

  assign full     = {in_mant, in_guard, in_round, in_sticky};
  assign low_mask = (ONE << (drop + IW'(1))) - ONE;
  assign g        = full[drop + IW'(2)];
  assign r        = full[drop + IW'(1)];
  assign s        = |(full & low_mask);
  assign inexact  = g | r | s;
  assign kept     = in_mant >> drop;
  assign lsb      = kept[0];

  always_comb begin
    case (rnd_mode)
      2'b00:   inc = g & (r | s | lsb);
      2'b10:   inc = inexact & in_sign;
      2'b11:   inc = inexact & ~in_sign;
      default: inc = 1'b0;
    endcase
  end

  assign sum     = {1'b0, kept} + {{MW{1'b0}}, inc};
  assign carry   = sum[IW'(MW) - drop];
  assign rounded = carry ? sum[MW:1] : sum[MW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_mant    <= '0;
      out_inexact <= 1'b0;
      out_trap    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_trap  <= in_valid & inexact & trap_en;
      if (in_valid) begin
        out_sign    <= in_sign;
        out_exp     <= in_exp + {{(EW-1){1'b0}}, carry};
        out_mant    <= rounded << drop;
        out_inexact <= inexact;
      end
    end
  end
endmodule

module rnd_unit_chk #(
  parameter int MW    = 64,
  parameter int EW    = 16,
  parameter int SGL_W = 24,
  parameter int DBL_W = 53
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sign,
  input logic [EW-1:0] in_exp,
  input logic [MW-1:0] in_mant,
  input logic          in_guard,
  input logic          in_round,
  input logic          in_sticky,
  input logic [1:0]    rnd_mode,
  input logic [1:0]    rnd_prec,
  input logic          trap_en,
  input logic          out_valid,
  input logic          out_sign,
  input logic [EW-1:0] out_exp,
  input logic [MW-1:0] out_mant,
  input logic          out_inexact,
  input logic          out_trap
);
  assert_trap_implies_inexact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_trap |-> (out_valid && out_inexact));

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_exact_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rnd_prec == 2'b00 && !in_guard && !in_round && !in_sticky) |=>
      (out_mant == $past(in_mant) && out_exp == $past(in_exp) && !out_inexact));

  assert_chop_keeps_exp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rnd_mode == 2'b01) |=> out_exp == $past(in_exp));

  assert_single_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rnd_prec == 2'b01) |=> out_mant[MW-SGL_W-1:0] == '0);

  assert_double_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rnd_prec == 2'b10) |=> out_mant[MW-DBL_W-1:0] == '0);

  assert_norm_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mant[MW-1]) |=> out_mant[MW-1]);

  assert_sign_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_sign == $past(in_sign));
endmodule

bind rnd_unit rnd_unit_chk #(.MW(MW), .EW(EW), .SGL_W(SGL_W), .DBL_W(DBL_W)) u_chk (.*);

// File: tb/sim_rnd_unit.sv
module sim_rnd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sign = 1'b0;
  logic [15:0] in_exp = '0;
  logic [63:0] in_mant = '0;
  logic        in_guard = 1'b0, in_round = 1'b0, in_sticky = 1'b0;
  logic [1:0]  rnd_mode = '0, rnd_prec = '0;
  logic        trap_en = 1'b0;
  logic        out_valid, out_sign, out_inexact, out_trap;
  logic [15:0] out_exp;
  logic [63:0] out_mant;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rnd_unit u0 (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  prec;
    logic        sign;
    logic        te;
    logic [2:0]  grs;
    logic [63:0] mant;
    logic [63:0] x_mant;
    logic        x_einc;
    logic        x_inex;
    logic        x_trap;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // R1 exact extended
    '{2'b00, 2'b00, 1'b0, 1'b0, 3'b000, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b0, 1'b0, 1'b0},
    // R4 tie even
    '{2'b00, 2'b00, 1'b0, 1'b0, 3'b100, 64'h8000_0000_0000_0002, 64'h8000_0000_0000_0002, 1'b0, 1'b1, 1'b0},
    // R4 tie odd, R9 trap
    '{2'b00, 2'b00, 1'b0, 1'b1, 3'b100, 64'h8000_0000_0000_0003, 64'h8000_0000_0000_0004, 1'b0, 1'b1, 1'b1},
    // R4 above half
    '{2'b00, 2'b00, 1'b0, 1'b0, 3'b101, 64'h8000_0000_0000_0002, 64'h8000_0000_0000_0003, 1'b0, 1'b1, 1'b0},
    // R4 below half, R2
    '{2'b00, 2'b00, 1'b0, 1'b0, 3'b011, 64'h8000_0000_0000_0002, 64'h8000_0000_0000_0002, 1'b0, 1'b1, 1'b0},
    // R5 chop
    '{2'b01, 2'b00, 1'b1, 1'b0, 3'b111, 64'h8000_0000_0000_0003, 64'h8000_0000_0000_0003, 1'b0, 1'b1, 1'b0},
    // R3 minus inf, negative
    '{2'b10, 2'b00, 1'b1, 1'b0, 3'b001, 64'h8000_0000_0000_0002, 64'h8000_0000_0000_0003, 1'b0, 1'b1, 1'b0},
    // R3 minus inf, positive
    '{2'b10, 2'b00, 1'b0, 1'b0, 3'b001, 64'h8000_0000_0000_0002, 64'h8000_0000_0000_0002, 1'b0, 1'b1, 1'b0},
    // R3 plus inf, positive
    '{2'b11, 2'b00, 1'b0, 1'b0, 3'b010, 64'h8000_0000_0000_0002, 64'h8000_0000_0000_0003, 1'b0, 1'b1, 1'b0},
    // R3 plus inf, negative
    '{2'b11, 2'b00, 1'b1, 1'b0, 3'b010, 64'h8000_0000_0000_0002, 64'h8000_0000_0000_0002, 1'b0, 1'b1, 1'b0},
    // R6 carry at extended
    '{2'b11, 2'b00, 1'b0, 1'b0, 3'b001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1, 1'b1, 1'b0},
    // R7 single tie even
    '{2'b00, 2'b01, 1'b0, 1'b0, 3'b000, 64'h8000_0080_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0},
    // R7 single tie odd
    '{2'b00, 2'b01, 1'b0, 1'b0, 3'b000, 64'h8000_0180_0000_0000, 64'h8000_0200_0000_0000, 1'b0, 1'b1, 1'b0},
    // R6 carry at single
    '{2'b00, 2'b01, 1'b0, 1'b0, 3'b000, 64'hFFFF_FF80_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b1, 1'b0},
    // R7 single, only input sticky set
    '{2'b11, 2'b01, 1'b0, 1'b0, 3'b001, 64'h8000_0000_0000_0000, 64'h8000_0100_0000_0000, 1'b0, 1'b1, 1'b0},
    // R7 double chop of folded guard
    '{2'b01, 2'b10, 1'b0, 1'b0, 3'b000, 64'h8000_0000_0000_0400, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0},
    // R7 double tie odd
    '{2'b00, 2'b10, 1'b0, 1'b0, 3'b000, 64'h8000_0000_0000_0C00, 64'h8000_0000_0000_1000, 1'b0, 1'b1, 1'b0},
    // R1 double exact, R9 no trap
    '{2'b00, 2'b10, 1'b0, 1'b1, 3'b000, 64'h8000_0000_0000_0800, 64'h8000_0000_0000_0800, 1'b0, 1'b0, 1'b0},
    // R1 single exact under minus inf
    '{2'b10, 2'b01, 1'b1, 1'b0, 3'b000, 64'hFFFF_FF00_0000_0000, 64'hFFFF_FF00_0000_0000, 1'b0, 1'b0, 1'b0},
    // R7 reserved precision acts as extended
    '{2'b00, 2'b11, 1'b0, 1'b0, 3'b110, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0002, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sign   = v.sign;
    in_exp    = 16'h4000;
    in_mant   = v.mant;
    {in_guard, in_round, in_sticky} = v.grs;
    rnd_mode  = v.mode;
    rnd_prec  = v.prec;
    trap_en   = v.te;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 valid", {63'b0, out_valid}, 64'd0);
    check("R10 mant", out_mant, 64'd0);
    check("R10 exp", {48'b0, out_exp}, 64'd0);
    check("R10 flags", {62'b0, out_inexact, out_trap}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R8 valid v%0d", i), {63'b0, out_valid}, 64'd1);
      check($sformatf("R1-R7 mant v%0d", i), out_mant, VECS[i].x_mant);
      check($sformatf("R6 exp v%0d", i), {48'b0, out_exp}, {48'b0, 16'h4000 + {15'b0, VECS[i].x_einc}});
      check($sformatf("R2 inexact v%0d", i), {63'b0, out_inexact}, {63'b0, VECS[i].x_inex});
      check($sformatf("R9 trap v%0d", i), {63'b0, out_trap}, {63'b0, VECS[i].x_trap});
      check($sformatf("R8 sign v%0d", i), {63'b0, out_sign}, {63'b0, VECS[i].sign});
    end

    // R8: idle cycle drops valid and holds data
    @(negedge clk);
    check("R8 idle valid", {63'b0, out_valid}, 64'd0);
    check("R8 idle hold", out_mant, VECS[NV-1].x_mant);
    check("R9 idle trap", {63'b0, out_trap}, 64'd0);

    // R8: inputs changing without valid leave outputs unchanged
    in_mant = 64'h1234_5678_9ABC_DEF0;
    in_exp  = 16'h0001;
    @(negedge clk);
    @(negedge clk);
    check("R8 ignore mant", out_mant, VECS[NV-1].x_mant);
    check("R8 ignore exp", {48'b0, out_exp}, 64'h4000);

    // R10: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 re-reset", {out_mant[0], out_mant[63], out_valid, out_inexact, 60'b0}, 64'd0);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule